// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Date Alarm

This block keeps wall-clock time in packed BCD: seconds, minutes, hours (24-hour), day of month, month and a two-digit year that stands for 2000 to 2099. It advances once every `TICKS_PER_SEC` pulses of a slow tick enable, which is nominally a 32768 Hz strobe synchronised into the system clock domain. Software reaches it through a byte-wide register port. The port holds the six time fields, six alarm fields, a control byte, a status byte and an interrupt-enable byte. Writes are registered. Reads are combinational from the address.

Each seconds update carries through the calendar in one clock. The update honours month lengths and leap Februaries. It records which fields carried, and sets an alarm flag when the new time equals every alarm field. A one-cycle timer pulse per second and a level alarm interrupt are each gated by an enable bit. A busy bit marks the prescaler's final count. Only on the edge that ends that count can the calendar move by itself.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads year 00, month 01, day 01, hours 00, minutes 00, seconds 00. The alarm fields read 00, control reads 0x00, status reads 0x80 and interrupt enable reads 0x00.
- R2: While control bit 0 is one, each tick enable advances the prescaler, and the seconds field steps once every `TICKS_PER_SEC` ticks. While the bit is zero the prescaler and the time hold. The other control bits read zero.
- R3: Seconds wrap 59 to 00, minutes wrap 59 to 00, hours wrap 23 to 00, month wraps 12 to 01 and year wraps 99 to 00. Each wrap carries one into the next field in the same update.
- R4: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In February it wraps after day 29 when the year's value is a multiple of 4, and after day 28 otherwise.
- R5: Busy (status bit 0) is one exactly while the clock runs and the prescaler sits at its last count. Without a host write, the time registers change only on a clock edge where a tick arrives while busy is one.
- R6: The status byte reads, from bit 7 down: power-up, alarm, day carried, hour carried, minute carried, second updated, run (a copy of control bit 0), busy. The four carry bits describe the most recent update and hold until the next one.
- R7: Writing status with bit 7 or bit 6 set clears power-up or alarm respectively. A zero in those positions leaves the flag unchanged. When an alarm match and an alarm clear fall in the same cycle, the flag ends set.
- R8: The alarm flag sets at the update whose new time equals all six alarm fields. `alarmIrq` is high whenever that flag and interrupt-enable bit 3 are both one.
- R9: With interrupt-enable bit 2 set, `timerIrq` is high for exactly the one clock cycle after each seconds update. With the bit clear it stays low.
- R10: Writes at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 replace seconds, minutes, hours, day, month and year at the next edge, and override an update in the same cycle. The alarm fields sit at 0x20 to 0x34 in the same order. Control is at 0x40, status at 0x44, and interrupt enable at 0x48, which keeps only bits 3 and 2. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle strobe per oscillator period |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| timerIrq | output | 1 | Once-per-second pulse |
| alarmIrq | output | 1 | Alarm interrupt level |

## Verification
An alarm match and a software write-one-to-clear of the alarm flag can land in the same cycle. So can a seconds update and a host write to a time field. The bench provokes the first case by writing 0x40 to status on every cycle while ticks run toward a programmed alarm. The reference model then expects the flag to be seen high for exactly one cycle before the next write removes it. A pure clear must still take effect when no match is present. The update-versus-write case is judged by the same per-cycle model: the written field wins, and the other fields advance from the old values.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int FIELDS = 6;
  localparam int BYTE_W = 8;

  typedef logic [FIELDS-1:0][BYTE_W-1:0] calVec_t;

  typedef struct packed {
    logic              adv;
    logic [FIELDS-1:0] wrTime;
    logic [FIELDS-1:0] wrAlarm;
    logic [BYTE_W-1:0] data;
  } dpStrobe_t;

  function automatic logic [7:0] bcdToBin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [7:0] monBin,
                                              input logic [7:0] yrBin);
    case (monBin)
      8'd2:                      return (yrBin[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strb,
  output calVec_t   timeQ,
  output calVec_t   alarmQ,
  output logic [2:0] carryEv,
  output logic      alarmHit
);
  // field order: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year
  localparam calVec_t BASE = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  calVec_t            binV;
  calVec_t            fieldLim;
  calVec_t            nextV;
  logic [FIELDS:0]    carry;
  logic [FIELDS-1:0]  wrapF;

  always_comb begin
    for (int i = 0; i < FIELDS; i++) binV[i] = bcdToBin(timeQ[i]);
    fieldLim[0] = 8'd59;
    fieldLim[1] = 8'd59;
    fieldLim[2] = 8'd23;
    fieldLim[3] = daysInMonth(binV[4], binV[5]);
    fieldLim[4] = 8'd12;
    fieldLim[5] = 8'd99;
    carry[0] = 1'b1;
    for (int i = 0; i < FIELDS; i++) begin
      wrapF[i]     = carry[i] && (binV[i] >= fieldLim[i]);
      carry[i+1]   = wrapF[i];
      if (!carry[i])     nextV[i] = timeQ[i];
      else if (wrapF[i]) nextV[i] = BASE[i];
      else               nextV[i] = bcdInc(timeQ[i]);
    end
  end

  assign carryEv  = carry[3:1];
  assign alarmHit = (nextV == alarmQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ  <= BASE;
      alarmQ <= '0;
    end else begin
      for (int i = 0; i < FIELDS; i++) begin
        if (strb.wrTime[i])  timeQ[i] <= strb.data;
        else if (strb.adv)   timeQ[i] <= nextV[i];
        if (strb.wrAlarm[i]) alarmQ[i] <= strb.data;
      end
    end
  end

  // R5: calendar moves only on an update or a host write
  p_hold_time_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adv && strb.wrTime == '0) |=> $stable(timeQ));

  // R3: seconds wrap from 59 to 00
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.wrTime[0] && timeQ[0] == 8'h59) |=> timeQ[0] == 8'h00);
endmodule

// File: rtl/rtc_control.sv
`timescale 1ns/1ps
module rtc_control
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 7
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  calVec_t           timeQ,
  input  calVec_t           alarmQ,
  input  logic [2:0]        carryEv,
  input  logic              alarmHit,
  output dpStrobe_t         strb,
  output logic [BYTE_W-1:0] rdData,
  output logic              timerIrq,
  output logic              alarmIrq
);
  localparam int PRE_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] LAST_CNT = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] IEN_ADR  = ADDR_W'('h48);

  logic [PRE_W-1:0] prescQ;
  logic             runQ, pwrQ, almQ, ienAlmQ, ienTmrQ, timerQ;
  logic [3:0]       evQ;
  logic             busy, adv, stWr;
  logic [2:0]       fieldSel;
  logic             aligned, timeSpace, alarmSpace;
  logic [FIELDS-1:0] wrT, wrA;

  assign busy       = runQ && (prescQ == LAST_CNT);
  assign adv        = busy && tickEn;
  assign fieldSel   = addr[4:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign timeSpace  = (addr[ADDR_W-1:5] == '0);
  assign alarmSpace = (addr[ADDR_W-1:5] == (ADDR_W-5)'(1));
  assign stWr       = wrEn && (addr == STAT_ADR);

  for (genvar i = 0; i < FIELDS; i++) begin : g_dec
    assign wrT[i] = wrEn && aligned && timeSpace  && (fieldSel == 3'(i));
    assign wrA[i] = wrEn && aligned && alarmSpace && (fieldSel == 3'(i));
  end

  assign strb.adv     = adv;
  assign strb.wrTime  = wrT;
  assign strb.wrAlarm = wrA;
  assign strb.data    = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ  <= '0;
      runQ    <= 1'b0;
      pwrQ    <= 1'b1;
      almQ    <= 1'b0;
      evQ     <= '0;
      ienAlmQ <= 1'b0;
      ienTmrQ <= 1'b0;
      timerQ  <= 1'b0;
    end else begin
      if (runQ && tickEn) prescQ <= (prescQ == LAST_CNT) ? '0 : prescQ + PRE_W'(1);
      if (adv) evQ <= {carryEv, 1'b1};
      if (adv && alarmHit)          almQ <= 1'b1;
      else if (stWr && wrData[6])   almQ <= 1'b0;
      if (stWr && wrData[7])        pwrQ <= 1'b0;
      if (wrEn && addr == CTRL_ADR) runQ <= wrData[0];
      if (wrEn && addr == IEN_ADR) begin
        ienAlmQ <= wrData[3];
        ienTmrQ <= wrData[2];
      end
      timerQ <= adv && ienTmrQ;
    end
  end

  assign timerIrq = timerQ;
  assign alarmIrq = ienAlmQ && almQ;

  always_comb begin
    rdData = '0;
    if (aligned && (timeSpace || alarmSpace)) begin
      for (int k = 0; k < FIELDS; k++)
        if (fieldSel == 3'(k)) rdData = timeSpace ? timeQ[k] : alarmQ[k];
    end
    case (addr)
      CTRL_ADR: rdData = {7'b0, runQ};
      STAT_ADR: rdData = {pwrQ, almQ, evQ, runQ, busy};
      IEN_ADR:  rdData = {4'b0, ienAlmQ, ienTmrQ, 2'b0};
      default:  ;
    endcase
  end

  // R2: prescaler frozen while stopped
  p_freeze_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> $stable(prescQ));

  // R7: a zero in bit 7 of a status write keeps power-up
  p_pwr_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !wrData[7]) |=> pwrQ == $past(pwrQ));

  // R8: the alarm flag rises only with time equal to alarm
  p_alarm_eq_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(almQ) && $past(wrT) == '0 && $past(wrA) == '0) |-> timeQ == alarmQ);

  // R9: timer interrupt lasts one cycle
  p_timer_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |=> !timerIrq);

  initial p_ticks_min_r2: assert (TICKS_PER_SEC >= 2);
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 7
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              timerIrq,
  output logic              alarmIrq
);
  dpStrobe_t  strb;
  calVec_t    timeQ, alarmQ;
  logic [2:0] carryEv;
  logic       alarmHit;

  rtc_control #(.TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .timeQ(timeQ), .alarmQ(alarmQ), .carryEv(carryEv),
    .alarmHit(alarmHit), .strb(strb), .rdData(rdData),
    .timerIrq(timerIrq), .alarmIrq(alarmIrq)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeQ(timeQ), .alarmQ(alarmQ),
    .carryEv(carryEv), .alarmHit(alarmHit)
  );
endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic timerIrq, alarmIrq;

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference model state (binary values)
  int mT[6], mA[6];
  int mPre;
  bit mRun, mPwr, mAlm, mIenA, mIenT, mTmr;
  bit [3:0] mEv;

  always #2 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timerIrq(timerIrq), .alarmIrq(alarmIrq)
  );

  function automatic int toBcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int fromBcd(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic int monLen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int expRead(int a);
    bit busy;
    busy = mRun && (mPre == TPS - 1);
    if (a < 'h18 && a % 4 == 0) return toBcd(mT[a / 4]);
    if (a >= 'h20 && a < 'h38 && a % 4 == 0) return toBcd(mA[(a - 'h20) / 4]);
    if (a == 'h40) return int'(mRun);
    if (a == 'h44) return (int'(mPwr) << 7) | (int'(mAlm) << 6) | (int'(mEv) << 2)
                          | (int'(mRun) << 1) | int'(busy);
    if (a == 'h48) return (int'(mIenA) << 3) | (int'(mIenT) << 2);
    return 0;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit tk, input bit we, input int a, input int d);
    int nt[6];
    bit adv, hit, c1, c2, c3;
    adv = mRun && (mPre == TPS - 1) && tk;
    nt = mT;
    hit = 1'b0;
    if (mRun && tk) mPre = (mPre == TPS - 1) ? 0 : mPre + 1;
    if (adv) begin
      c1 = (nt[0] == 59); nt[0] = c1 ? 0 : nt[0] + 1;
      c2 = 1'b0; c3 = 1'b0;
      if (c1) begin c2 = (nt[1] == 59); nt[1] = c2 ? 0 : nt[1] + 1; end
      if (c2) begin c3 = (nt[2] == 23); nt[2] = c3 ? 0 : nt[2] + 1; end
      if (c3) begin
        if (nt[3] == monLen(nt[4], nt[5])) begin
          nt[3] = 1;
          if (nt[4] == 12) begin nt[4] = 1; nt[5] = (nt[5] == 99) ? 0 : nt[5] + 1; end
          else nt[4] = nt[4] + 1;
        end else nt[3] = nt[3] + 1;
      end
      hit = (nt == mA);
      mEv = {c3, c2, c1, 1'b1};
      if (hit) mAlm = 1'b1;
    end
    mTmr = adv && mIenT;
    if (we) begin
      if (a < 'h18 && a % 4 == 0) nt[a / 4] = fromBcd(d);
      if (a >= 'h20 && a < 'h38 && a % 4 == 0) mA[(a - 'h20) / 4] = fromBcd(d);
      if (a == 'h40) mRun = d[0];
      if (a == 'h44) begin
        if (d[7]) mPwr = 1'b0;
        if (d[6] && !hit) mAlm = 1'b0;
      end
      if (a == 'h48) begin mIenA = d[3]; mIenT = d[2]; end
    end
    mT = nt;
  endtask

  task automatic cyc(input bit tk, input bit we, input int a, input int d);
    @(negedge clk);
    tickEn = tk; wrEn = we; addr = 7'(a); wrData = 8'(d);
    #1;
    chk($sformatf("rdData@%0h", a), int'(rdData), expRead(a));
    chk("timerIrq (R9)", int'(timerIrq), int'(mTmr));
    chk("alarmIrq (R8)", int'(alarmIrq), int'(mIenA && mAlm));
    @(posedge clk);
    modelStep(tk, we, a, d);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(input int n, input int per);
    for (int k = 0; k < n; k++) begin
      int sel;
      sel = k % 7;
      cyc((k % per) == per - 1, 1'b0, (sel == 6) ? 'h44 : sel * 4, 0);
    end
  endtask

  task automatic setTime(input int y, input int mo, input int d, input int h,
                         input int mi, input int s);
    wr('h14, y); wr('h10, mo); wr('h0C, d); wr('h08, h); wr('h04, mi); wr('h00, s);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mT = '{0, 0, 0, 1, 1, 0};
    mA = '{0, 0, 0, 0, 0, 0};
    mPre = 0; mRun = 0; mPwr = 1; mAlm = 0; mIenA = 0; mIenT = 0; mTmr = 0; mEv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset contents of every register
    tag = "R1";
    for (int a = 0; a < 'h50; a += 4) cyc(1'b0, 1'b0, a, 0);

    // R7: write-one-to-clear of power-up
    tag = "R7";
    wr('h44, 'h00); cyc(1'b0, 1'b0, 'h44, 0);
    wr('h44, 'h80); cyc(1'b0, 1'b0, 'h44, 0);

    // R10: register writes and masking
    tag = "R10";
    setTime('h24, 'h02, 'h28, 'h23, 'h59, 'h58);
    wr('h40, 'hFE); cyc(1'b0, 1'b0, 'h40, 0);
    wr('h40, 'h01); wr('h48, 'hFF);
    for (int a = 0; a < 'h50; a += 4) cyc(1'b0, 1'b0, a, 0);

    // R4: leap and short month day wrap
    tag = "R4";
    run(24, 1);
    setTime('h24, 'h02, 'h29, 'h23, 'h59, 'h59); run(12, 1);
    setTime('h23, 'h02, 'h28, 'h23, 'h59, 'h59); run(12, 1);
    setTime('h23, 'h04, 'h30, 'h23, 'h59, 'h59); run(12, 1);

    // R3: full carry chain including year wrap
    tag = "R3";
    setTime('h99, 'h12, 'h31, 'h23, 'h59, 'h59); run(14, 1);

    // R6: status event bits over plain seconds
    tag = "R6";
    run(21, 1);

    // R2: stopped clock holds
    tag = "R2";
    wr('h40, 'h00); run(21, 1); wr('h40, 'h01);

    // R5: sparse ticks stretch busy
    tag = "R5";
    run(42, 3);

    // R10: host write to seconds in the update cycle
    tag = "R10";
    for (int k = 0; k < 8; k++) cyc(1'b1, 1'b1, 'h00, 'h30);

    // R8: full-date alarm match
    tag = "R8";
    wr('h48, 'h08);
    setTime('h30, 'h12, 'h01, 'h10, 'h00, 'h00);
    wr('h34, 'h30); wr('h30, 'h12); wr('h2C, 'h01);
    wr('h28, 'h10); wr('h24, 'h00); wr('h20, 'h03);
    run(21, 1);
    wr('h44, 'h40); cyc(1'b0, 1'b0, 'h44, 0);

    // R7: alarm clear collides with alarm match
    tag = "R7";
    wr('h20, 'h06);
    for (int k = 0; k < 16; k++) cyc(1'b1, 1'b1, 'h44, 'h40);
    run(7, 1);

    // R9: timer pulse gated by its enable
    tag = "R9";
    wr('h48, 'h04); run(14, 1);
    wr('h48, 'h00); run(14, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule